// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Coherent Readback

This block is a 16-bit up-counter that software reaches through an 8-bit register bus. The bus has three addresses: one for the low byte, one for the high byte and one for control. The counter advances either on a prescaled clock-enable strobe or on synchronised edges of an external event pin. When it wraps past all ones, it reloads from a preload register and raises a one-cycle overflow interrupt.

Software sees the counter one byte at a time, so the block uses a byte buffer to keep each access coherent. Reading the high byte returns the live high byte and, on the same edge, copies the live low byte into the buffer. A later read of the low byte returns that copy. In the write direction, writing the low byte only fills the buffer. Writing the high byte then commits the high byte and the buffered byte to the preload register as one 16-bit value. While the timer is stopped, that same high-byte write also loads the counter.

The bus is a plain register interface with no back-pressure. A write or read completes in the cycle its strobe is high, and read data is combinational from the address. Control bits: [1:0] mode (00 off, 01 event count, 10 clock-enable count, 11 treated as off), [2] run, [3] event edge select (0 rising, 1 falling).

Top module: `tmr16_latched`

## Requirements
- R1: `ovf_irq` is high for exactly one cycle, in the cycle after an advance from 16'hFFFF, and is low at every other time.
- R2: A read at address 1 returns the live counter bits [15:8] and, on the same clock edge, copies the live counter bits [7:0] into the low-byte buffer.
- R3: A read at address 0 returns the low-byte buffer, never the live counter low byte, however far the counter has moved since the buffer was filled.
- R4: A write at address 0 stores the data only in the low-byte buffer; the preload register and the counter keep their values.
- R5: A write at address 1 sets the preload register to {write data, low-byte buffer} in one step.
- R6: When the timer is stopped (run bit 0, or mode 00 or 11), a write at address 1 also loads the counter with the new preload value. While the timer is running, such a write leaves the counter's own progress untouched.
- R7: An advance from 16'hFFFF loads the counter with the preload value held before that edge, and counting then continues from there.
- R8: With mode 10 and run set, the counter advances by one on every clock where `tick_en` is high, and only then; `ev_in` has no effect.
- R9: With mode 01 and run set, each edge of `ev_in` of the selected polarity advances the counter by one. If the pin changes between edges k-1 and k, the counter changes at edge k+2. `tick_en` has no effect in this mode.
- R10: After reset the control register, counter, preload and buffer are all zero, the timer is off, and a read at address 2 returns {4'b0, edge select, run, mode}.
- R11: Mode 11 and mode 00 never advance the counter, whatever `tick_en`, `ev_in` and the run bit do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ev_in | input | 1 | External event pin, asynchronous |
| tick_en | input | 1 | Prescaled count enable for mode 10 |
| ovf_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
Read data is due in the same cycle as the read strobe. The effects of a write or read on the buffer, preload and counter appear one edge later, and `ovf_irq` rises in the cycle after the wrapping advance. An event-pin change shows up in the count two edges after the edge that first samples it.

The bench drives every input just after a falling edge. A moment later it compares `bus_rdata` and `ovf_irq` against a behavioural model. The model advances at each rising edge from the same inputs and keeps a short history of pin samples to reproduce the two-edge event delay. Because the model and the design move on the same edge, each result is checked in exactly the cycle it is due.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_CLOCK = 2'b10,
    MODE_RSVD  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      fall_sel;
    logic      run;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/tmr16_evsync.sv
module tmr16_evsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  input  logic fall_sel,
  output logic edge_pulse
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < CHAIN_W; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= ev_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  logic cur_lvl, prev_lvl;
  assign cur_lvl  = chain[SYNC_STAGES-1];
  assign prev_lvl = chain[SYNC_STAGES];
  assign edge_pulse = fall_sel ? (prev_lvl & ~cur_lvl) : (cur_lvl & ~prev_lvl);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && !fall_sel) |=> (!edge_pulse || fall_sel)) else $error("edge pulse repeated"); // R9
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  logic [2*BYTE_W-1:0] count,
  output logic [BYTE_W-1:0]   bus_rdata,
  output tmr_ctrl_t           ctrl,
  output logic                running,
  output logic [2*BYTE_W-1:0] preload,
  output logic                load_req,
  output logic [2*BYTE_W-1:0] load_val
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] low_buf;
  logic wr_lo, wr_hi, wr_ctrl, rd_hi;

  assign wr_lo   = bus_wr && bus_addr == ADDR_LO;
  assign wr_hi   = bus_wr && bus_addr == ADDR_HI;
  assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
  assign rd_hi   = bus_rd && bus_addr == ADDR_HI;

  assign running  = ctrl.run && (ctrl.mode == MODE_EVENT || ctrl.mode == MODE_CLOCK);
  assign load_val = {bus_wdata, low_buf};
  assign load_req = wr_hi && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      low_buf <= '0;
      preload <= '0;
    end else begin
      if (wr_ctrl) ctrl <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_lo)   low_buf <= bus_wdata;
      else if (rd_hi) low_buf <= count[BYTE_W-1:0];
      if (wr_hi)   preload <= load_val;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_LO:   bus_rdata = low_buf;
      ADDR_HI:   bus_rdata = count[CNT_W-1:BYTE_W];
      ADDR_CTRL: bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
      default:   bus_rdata = '0;
    endcase
  end

  AST_LO_WR_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> $stable(preload)) else $error("low write touched preload"); // R4
  AST_HI_WR_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> preload == {$past(bus_wdata), $past(low_buf)}) else $error("preload not committed"); // R5
  AST_HI_RD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> low_buf == $past(count[BYTE_W-1:0])) else $error("low byte not latched"); // R2
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             ovf_irq
);
  logic wrap;
  assign wrap = inc && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      ovf_irq <= 1'b0;
    end else begin
      ovf_irq <= 1'b0;
      if (load) begin
        count <= load_val;
      end else if (inc) begin
        if (wrap) begin
          count   <= preload;
          ovf_irq <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  AST_IRQ_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && !load && (&count)) |=> !ovf_irq) else $error("spurious irq"); // R1
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (&count)) |=> (ovf_irq && count == $past(preload))) else $error("bad reload"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(count)) else $error("count moved while idle"); // R6
endmodule

// File: rtl/tmr16_latched.sv
module tmr16_latched
  import tmr16_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ev_in,
  input  logic              tick_en,
  output logic              ovf_irq
);
  localparam int CNT_W = 2 * BYTE_W;

  tmr_ctrl_t        ctrl;
  logic             running, load_req, edge_pulse, inc;
  logic [CNT_W-1:0] count, preload, load_val;

  tmr16_evsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in),
    .fall_sel(ctrl.fall_sel), .edge_pulse(edge_pulse)
  );

  tmr16_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
    .bus_rdata(bus_rdata), .ctrl(ctrl), .running(running),
    .preload(preload), .load_req(load_req), .load_val(load_val)
  );

  assign inc = running &&
               ((ctrl.mode == MODE_CLOCK && tick_en) ||
                (ctrl.mode == MODE_EVENT && edge_pulse));

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(inc), .load(load_req),
    .load_val(load_val), .preload(preload), .count(count), .ovf_irq(ovf_irq)
  );

  AST_OFF_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.mode == MODE_OFF || ctrl.mode == MODE_RSVD) && !load_req) |=> $stable(count)) else $error("count moved in off mode"); // R11
endmodule

// File: tb/tmr16_latched_test.sv
module tmr16_latched_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ev_in = 1'b0, tick_en = 1'b0;
  logic       ovf_irq;

  tmr16_latched uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_in(ev_in), .tick_en(tick_en), .ovf_irq(ovf_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 1'b0;
  string tag = "R10";

  // behavioural reference state
  int m_cnt = 0, m_pre = 0, m_buf = 0, m_ctrl = 0;
  bit m_irq = 1'b0;
  bit hist [3] = '{1'b0, 1'b0, 1'b0}; // hist[0] newest pin sample

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_buf = 0; m_ctrl = 0; m_irq = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      int mode, old_cnt, old_pre;
      bit run, fall, active, evedge, adv;
      mode = m_ctrl & 3; run = m_ctrl[2]; fall = m_ctrl[3];
      active = run && (mode == 1 || mode == 2);
      evedge = fall ? (!hist[1] && hist[2]) : (hist[1] && !hist[2]);
      adv = active && ((mode == 2 && tick_en) || (mode == 1 && evedge));
      old_cnt = m_cnt; old_pre = m_pre;
      m_irq = 1'b0;
      if (bus_wr && bus_addr == 2'd1) begin
        m_pre = (int'(bus_wdata) << 8) | m_buf;
        if (!active) m_cnt = m_pre;
      end
      if (!(bus_wr && bus_addr == 2'd1 && !active) && adv) begin
        if (old_cnt == 16'hFFFF) begin m_cnt = old_pre; m_irq = 1'b1; end
        else m_cnt = old_cnt + 1;
      end
      if (bus_wr && bus_addr == 2'd0) m_buf = bus_wdata;
      else if (bus_rd && bus_addr == 2'd1) m_buf = old_cnt & 8'hFF;
      if (bus_wr && bus_addr == 2'd2) m_ctrl = bus_wdata & 4'hF;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = ev_in;
    end
  end

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_buf;
      2'd1: return (m_cnt >> 8) & 8'hFF;
      2'd2: return m_ctrl;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit wr, input bit rd, input logic [1:0] a,
                      input logic [7:0] d, input bit tk, input bit ev);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_en = tk; ev_in = ev;
    #1;
    n_cmp++;
    if (ovf_irq !== m_irq) begin
      n_bad++;
      $display("FAIL R1 irq: actual %0b expected %0b (during %s)", ovf_irq, m_irq, tag);
    end
    if (rd) begin
      n_cmp++;
      if (bus_rdata !== 8'(exp_rd(a))) begin
        n_bad++;
        $display("FAIL %s read addr %0d: actual %02h expected %02h", tag, a, bus_rdata, exp_rd(a));
      end
    end
  endtask

  task automatic idle(input int n, input bit tk, input bit ev);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'd0, tk, ev);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0, ev_in);
  endtask

  task automatic rd(input logic [1:0] a);
    step(0, 1, a, 8'd0, 0, ev_in);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R10"; rd(2'd2); rd(2'd1); rd(2'd0);
    tag = "R4";  wr(2'd0, 8'h34); rd(2'd0); rd(2'd1); idle(2, 1, 0);
    tag = "R5";  wr(2'd1, 8'h12); rd(2'd1); rd(2'd0);
    tag = "R6";  rd(2'd1); rd(2'd0);
    tag = "R8";  wr(2'd2, 8'h06);
    for (int i = 0; i < 20; i++) step(0, 0, 2'd0, 8'd0, i % 3 != 0, i % 2);
    rd(2'd1); rd(2'd0);
    tag = "R6";  wr(2'd0, 8'h00); wr(2'd1, 8'h50); idle(3, 1, 0); rd(2'd1); rd(2'd0);
    tag = "R3";  rd(2'd1); idle(7, 1, 0); rd(2'd0); rd(2'd0);
    tag = "R7";  wr(2'd2, 8'h02); wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
    rd(2'd1); rd(2'd0); wr(2'd2, 8'h06);
    idle(14, 1, 0); tag = "R1"; idle(6, 1, 0); rd(2'd1); rd(2'd0);
    tag = "R7";  wr(2'd0, 8'hCD); wr(2'd1, 8'hAB); idle(12, 1, 0); rd(2'd1); rd(2'd0);
    idle(20, 1, 0); rd(2'd1); rd(2'd0);
    tag = "R9";  wr(2'd2, 8'h01); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h05);
    for (int i = 0; i < 30; i++) begin
      step(0, i % 5 == 0, 2'd1, 8'd0, 1, (i / 3) % 2);
      step(0, 1, 2'd0, 8'd0, 1, (i / 3) % 2);
    end
    wr(2'd2, 8'h0D);
    for (int i = 0; i < 24; i++) step(0, 1, 2'd1, 8'd0, 0, (i / 2) % 2);
    rd(2'd0); rd(2'd2);
    tag = "R11"; wr(2'd2, 8'h07);
    for (int i = 0; i < 10; i++) step(0, 1, 2'd1, 8'd0, 1, i % 2);
    wr(2'd2, 8'h04); idle(8, 1, 1); idle(4, 1, 0); rd(2'd1); rd(2'd0); rd(2'd2);
    tag = "R2";  wr(2'd2, 8'h06); idle(5, 1, 0);
    for (int i = 0; i < 6; i++) begin step(0, 1, 2'd1, 8'd0, 1, 0); rd(2'd0); end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule